// File: doc/BRIEF.md
# SDRAM Command Front End with Bank and Power-State Tracking

This block is the control-side front end of a behavioural DDR2-class SDRAM device model. On every rising clock edge it samples the active-low chip select and the row, column and write strobes, the two bank-address bits and a 14-bit address bus. From these it decodes one command. It keeps an open/idle flag and the open row for each of four banks, and it routes mode-register writes to one of two configuration registers.

It also follows the clock-enable input. When clock enable drops, the block enters one of three low-power states. A refresh command that arrives with clock enable low gives self refresh. Otherwise the state is precharge power-down when every bank is idle, or active power-down when any row is open. While the block is in any low-power state, commands are not executed. A model of the data path, burst timing and refresh can use the outputs to learn which rows are open and how the device is configured. A sticky flag reports command sequences that break the bank protocol.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, all `bank_open` bits are 0, `open_row` is all zero, both mode registers are 0, `pwr_state` is 0 (active) and `proto_err` is 0.
- R2: A cycle with `cs_n` sampled high leaves bank state, rows, mode registers and `proto_err` unchanged, whatever the other strobes, bank and address are.
- R3: An activate ({cs_n,ras_n,cas_n,we_n}=0011) to an idle bank opens that bank at the next edge and stores addr[12:0] as its row. addr[13] is ignored. The bank is numbered {ba[1],ba[0]}, and its row appears at `open_row[13*bank +: 13]`.
- R4: A precharge (0010) with addr[10]=0 closes only the bank selected by `ba`. With addr[10]=1 it closes all four banks. A closed bank reports row 0.
- R5: A mode register set (0000) with ba[0]=0 loads addr[12:0] into `mode_reg`. With ba[0]=1 it loads `ext_mode_reg`. The other register is unchanged.
- R6: When `cke` is sampled low in the active state, and the cycle is not a self-refresh entry, `pwr_state` becomes 2 (active power-down) if any bank is open and 1 (precharge power-down) if none is, at that edge.
- R7: A refresh command (0001) sampled with `cke` low, in the active state with all banks idle, sets `pwr_state` to 3 (self refresh) at that edge.
- R8: In a power-down state, the first edge that samples `cke` high returns `pwr_state` to 0. Commands are not executed on the entry edge, while the block is powered down, or on the exit edge.
- R9: Self refresh ends as soon as `cke` goes high. `pwr_state` shows 0 with no clock edge in between, and the next edge executes its command normally.
- R10: An activate to an open bank, or a read (0101) or write (0100) to an idle bank, sets `proto_err`. The flag stays set until reset, and the offending command changes no bank state.
- R11: Read, write, refresh with `cke` high, no-operation (0111) and the unused code 0110 leave bank state, rows and mode registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, controls the low-power states |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Row address, column address and op-code bus |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| open_row | output | 52 | Open row of each bank, 13 bits per bank |
| mode_reg | output | 13 | Mode register contents |
| ext_mode_reg | output | 13 | Extended mode register contents |
| pwr_state | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self refresh |
| proto_err | output | 1 | Sticky bank-protocol violation flag |

## Verification
A bank flag that is out of step with the command history shows up on `bank_open` one edge later. It also skews the power-down choice on the next clock-enable drop, and it turns a legal read or activate into a spurious `proto_err`. The bench therefore compares every output after every edge against its own model, so a divergence is reported in the cycle it appears. A self-refresh exit that waits for a clock edge is caught by a check taken between clock-enable rising and the next edge.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE   = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    unique case ({cs_n, ras_n, cas_n, we_n})
      4'b0011: cmd = CMD_ACT;
      4'b0101: cmd = CMD_RD;
      4'b0100: cmd = CMD_WR;
      4'b0010: cmd = CMD_PRE;
      4'b0001: cmd = CMD_REF;
      4'b0000: cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int ROW_W    = 13,
  parameter int BA_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] row_in,
  input  logic             pre_all,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  logic             sel;
  logic             upd;
  logic             open_d;
  logic [ROW_W-1:0] row_d;

  assign sel = (ba == BA_W'(BANK_IDX));

  always_comb begin
    upd    = 1'b0;
    open_d = open_o;
    row_d  = row_o;
    if (exec && sel && cmd == CMD_ACT && !open_o) begin
      upd    = 1'b1;
      open_d = 1'b1;
      row_d  = row_in;
    end else if (exec && cmd == CMD_PRE && (pre_all || sel)) begin
      upd    = 1'b1;
      open_d = 1'b0;
      row_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (upd) begin
      open_o <= open_d;
      row_o  <= row_d;
    end
  end

  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && sel && cmd == CMD_ACT) |=> open_o);

  p_pre_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == CMD_PRE && (pre_all || sel)) |=> (!open_o && row_o == '0));

  p_closed_row_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !open_o |-> (row_o == '0));
endmodule

// File: rtl/sdram_power_ctl.sv
module sdram_power_ctl
  import sdram_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  cmd_e cmd,
  input  logic any_open,
  output logic exec,
  output pwr_e pwr_state
);
  pwr_e pwr_q, pwr_d;
  logic sr_q, sr_d;
  logic sr_enter;

  assign sr_enter = !cke && pwr_q == PWR_ACTIVE && !sr_q
                    && cmd == CMD_REF && !any_open;

  always_comb begin
    pwr_d = pwr_q;
    sr_d  = sr_q;
    if (sr_q) begin
      if (cke) sr_d = 1'b0;
    end else if (pwr_q == PWR_ACTIVE) begin
      if (sr_enter)  sr_d  = 1'b1;
      else if (!cke) pwr_d = any_open ? PWR_ACT_PD : PWR_PRE_PD;
    end else if (cke) begin
      pwr_d = PWR_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PWR_ACTIVE;
      sr_q  <= 1'b0;
    end else begin
      pwr_q <= pwr_d;
      sr_q  <= sr_d;
    end
  end

  // Self-refresh exit is visible as soon as cke rises, no edge needed.
  assign pwr_state = (sr_q && !cke) ? PWR_SELF_REF : pwr_q;
  assign exec      = cke && pwr_q == PWR_ACTIVE;

  p_apd_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q == PWR_ACTIVE && !sr_q && !cke && any_open) |=> pwr_q == PWR_ACT_PD);

  p_ppd_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q == PWR_ACTIVE && !sr_q && !cke && !any_open && cmd != CMD_REF)
      |=> pwr_q == PWR_PRE_PD);

  p_sr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q |-> !any_open);

  p_pd_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q != PWR_ACTIVE && cke) |=> pwr_q == PWR_ACTIVE);

  p_sr_async_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> pwr_state != PWR_SELF_REF);
endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs
  import sdram_cmd_pkg::*;
#(
  parameter int MR_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec,
  input  cmd_e            cmd,
  input  logic            sel_ext,
  input  logic [MR_W-1:0] opcode,
  output logic [MR_W-1:0] mr_o,
  output logic [MR_W-1:0] emr_o
);
  logic ld_mr, ld_emr;

  assign ld_mr  = exec && cmd == CMD_MRS && !sel_ext;
  assign ld_emr = exec && cmd == CMD_MRS &&  sel_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mr_o <= '0;
    else if (ld_mr) mr_o <= opcode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      emr_o <= '0;
    else if (ld_emr) emr_o <= opcode;
  end

  p_mr_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == CMD_MRS && sel_ext) |=> $stable(mr_o));

  p_emr_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == CMD_MRS && !sel_ext) |=> $stable(emr_o));
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter  int BANKS  = 4,
  parameter  int ROW_W  = 13,
  parameter  int ADDR_W = 14,
  parameter  int AP_BIT = 10,
  localparam int BA_W   = $clog2(BANKS),
  localparam int MR_W   = ROW_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic [BANKS-1:0]       bank_open,
  output logic [BANKS*ROW_W-1:0] open_row,
  output logic [MR_W-1:0]        mode_reg,
  output logic [MR_W-1:0]        ext_mode_reg,
  output logic [1:0]             pwr_state,
  output logic                   proto_err
);
  cmd_e cmd;
  pwr_e pwr_e_st;
  logic exec;
  logic any_open;
  logic err_d;
  logic sel_open;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
    sdram_bank_slot #(.BANK_IDX(gi), .ROW_W(ROW_W), .BA_W(BA_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .exec   (exec),
      .cmd    (cmd),
      .ba     (ba),
      .row_in (addr[ROW_W-1:0]),
      .pre_all(addr[AP_BIT]),
      .open_o (bank_open[gi]),
      .row_o  (open_row[gi*ROW_W +: ROW_W])
    );
  end

  assign any_open = |bank_open;

  sdram_power_ctl u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cmd      (cmd),
    .any_open (any_open),
    .exec     (exec),
    .pwr_state(pwr_e_st)
  );
  assign pwr_state = pwr_e_st;

  sdram_mode_regs #(.MR_W(MR_W)) u_mr (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec   (exec),
    .cmd    (cmd),
    .sel_ext(ba[0]),
    .opcode (addr[MR_W-1:0]),
    .mr_o   (mode_reg),
    .emr_o  (ext_mode_reg)
  );

  assign sel_open = bank_open[ba];

  always_comb begin
    err_d = proto_err;
    if (exec && cmd == CMD_ACT && sel_open)                    err_d = 1'b1;
    if (exec && (cmd == CMD_RD || cmd == CMD_WR) && !sel_open) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= err_d;
  end

  p_cs_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(bank_open) && $stable(open_row)
              && $stable(mode_reg) && $stable(ext_mode_reg)
              && $stable(proto_err)));

  p_pd_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 || pwr_state == 2'd2) |=> ($stable(bank_open) && $stable(open_row)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_err_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == CMD_ACT && sel_open) |=> $stable(open_row));
endmodule

// File: tb/sdram_cmd_front_test.sv
`timescale 1ns/1ps
module sdram_cmd_front_test;
  localparam bit [3:0] C_ACT = 4'b0011, C_RD  = 4'b0101, C_WR  = 4'b0100,
                       C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000,
                       C_NOP = 4'b0111, C_UNU = 4'b0110;

  logic        clk, rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [13:0] addr;
  logic [3:0]  bank_open;
  logic [51:0] open_row;
  logic [12:0] mode_reg, ext_mode_reg;
  logic [1:0]  pwr_state;
  logic        proto_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit [3:0]  m_open;
  bit [12:0] m_row [4];
  bit [12:0] m_mr, m_emr;
  bit [1:0]  m_pwr;
  bit        m_sr, m_err;

  sdram_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_row(open_row), .mode_reg(mode_reg),
    .ext_mode_reg(ext_mode_reg), .pwr_state(pwr_state), .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [1:0] exp_pwr();
    return (m_sr && !cke) ? 2'd3 : m_pwr;
  endfunction

  task automatic check_all();
    expect_eq("R3 bank_open", bank_open, m_open);
    for (int i = 0; i < 4; i++) expect_eq("R3 open_row", open_row[i*13 +: 13], m_row[i]);
    expect_eq("R5 mode_reg", mode_reg, m_mr);
    expect_eq("R5 ext_mode_reg", ext_mode_reg, m_emr);
    expect_eq("R6 pwr_state", pwr_state, exp_pwr());
    expect_eq("R10 proto_err", proto_err, m_err);
  endtask

  task automatic model_reset();
    m_open = '0; m_mr = '0; m_emr = '0; m_pwr = '0; m_sr = 0; m_err = 0;
    for (int i = 0; i < 4; i++) m_row[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cke = 1; {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = 0; addr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  // One clock: drive at negedge, advance the model, compare after the edge.
  task automatic step(input bit k, input bit [3:0] c, input bit [1:0] b, input bit [13:0] a);
    bit [3:0]  n_open;
    bit [12:0] n_row [4];
    bit [12:0] n_mr, n_emr;
    bit [1:0]  n_pwr;
    bit        n_sr, n_err, any, ex, was_sr;
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    was_sr = m_sr;
    if (k) m_sr = 0;
    #1;
    if (was_sr && k) expect_eq("R9 async self-refresh exit", pwr_state, 0);
    n_open = m_open; n_mr = m_mr; n_emr = m_emr; n_pwr = m_pwr; n_sr = m_sr; n_err = m_err;
    for (int i = 0; i < 4; i++) n_row[i] = m_row[i];
    any = |m_open;
    ex  = k && m_pwr == 0 && !m_sr;
    if (ex) begin
      case (c)
        C_ACT: if (m_open[b]) n_err = 1; else begin n_open[b] = 1; n_row[b] = a[12:0]; end
        C_RD, C_WR: if (!m_open[b]) n_err = 1;
        C_PRE: for (int i = 0; i < 4; i++)
                 if (a[10] || i == int'(b)) begin n_open[i] = 0; n_row[i] = '0; end
        C_MRS: if (b[0]) n_emr = a[12:0]; else n_mr = a[12:0];
        default: ;
      endcase
    end
    if (!m_sr) begin
      if (m_pwr == 0) begin
        if (!k) begin
          if (c == C_REF && !any) n_sr = 1;
          else n_pwr = any ? 2'd2 : 2'd1;
        end
      end else if (k) n_pwr = 0;
    end
    @(posedge clk);
    #1;
    m_open = n_open; m_mr = n_mr; m_emr = n_emr; m_pwr = n_pwr; m_sr = n_sr; m_err = n_err;
    for (int i = 0; i < 4; i++) m_row[i] = n_row[i];
    check_all();
  endtask

  initial begin
    rst_n = 0; cke = 1; {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = 0; addr = 0;
    model_reset();
    void'($urandom(32'd4711));
    do_reset();
    #1;
    // R1 reset state
    expect_eq("R1 bank_open", bank_open, 0);
    expect_eq("R1 open_row", open_row, 0);
    expect_eq("R1 mode regs", {mode_reg, ext_mode_reg}, 0);
    expect_eq("R1 pwr_state", pwr_state, 0);
    expect_eq("R1 proto_err", proto_err, 0);

    // R5 mode register writes, A13 ignored
    step(1, C_MRS, 2'd0, 14'h2A5A);
    expect_eq("R5 mode_reg load", mode_reg, 13'h0A5A);
    step(1, C_MRS, 2'd1, 14'h1234);
    expect_eq("R5 ext load", ext_mode_reg, 13'h1234);
    expect_eq("R5 mode_reg kept", mode_reg, 13'h0A5A);

    // R3 activate bank 2
    step(1, C_ACT, 2'd2, 14'h3ABC);
    expect_eq("R3 bank2 open", bank_open, 4'b0100);
    expect_eq("R3 bank2 row", open_row[26 +: 13], 13'h1ABC);

    // R2 chip select high ignored
    step(1, 4'b1011, 2'd0, 14'h0055);
    step(1, 4'b1000, 2'd1, 14'h0777);
    expect_eq("R2 cs high ignored", {bank_open, mode_reg}, {4'b0100, 13'h0A5A});

    // R11 read/write/nop/unused/refresh leave state
    step(1, C_RD, 2'd2, 14'h0001);
    step(1, C_WR, 2'd2, 14'h0002);
    step(1, C_NOP, 2'd0, 14'h3FFF);
    step(1, C_UNU, 2'd3, 14'h3FFF);
    step(1, C_REF, 2'd0, 14'h0000);
    expect_eq("R11 no state change", {bank_open, open_row[26 +: 13]}, {4'b0100, 13'h1ABC});
    expect_eq("R11 no error", proto_err, 0);

    // R10 read to idle bank
    step(1, C_RD, 2'd1, 14'h0000);
    expect_eq("R10 read idle sets err", proto_err, 1);
    step(1, C_ACT, 2'd2, 14'h0111);
    expect_eq("R10 reopen keeps row", open_row[26 +: 13], 13'h1ABC);
    step(1, C_NOP, 2'd0, 14'h0);
    expect_eq("R10 sticky", proto_err, 1);

    // R4 single-bank precharge
    step(1, C_ACT, 2'd0, 14'h0005);
    step(1, C_PRE, 2'd0, 14'h0000);
    expect_eq("R4 single precharge", bank_open, 4'b0100);
    expect_eq("R4 closed row zero", open_row[0 +: 13], 0);

    // R6 active power-down, R8 commands blocked and exit
    step(0, C_NOP, 2'd0, 14'h0);
    expect_eq("R6 active power-down", pwr_state, 2);
    step(0, C_ACT, 2'd1, 14'h0033);
    expect_eq("R8 blocked in power-down", bank_open, 4'b0100);
    step(1, C_PRE, 2'd0, 14'h0400);
    expect_eq("R8 exit to active", pwr_state, 0);
    expect_eq("R8 exit edge ignored", bank_open, 4'b0100);
    step(1, C_PRE, 2'd3, 14'h0400);
    expect_eq("R4 all-bank precharge", bank_open, 4'b0000);

    // R6 precharge power-down
    step(0, C_ACT, 2'd3, 14'h0009);
    expect_eq("R6 precharge power-down", pwr_state, 1);
    expect_eq("R8 entry edge ignored", bank_open, 4'b0000);
    step(1, C_NOP, 2'd0, 14'h0);
    expect_eq("R8 exit ppd", pwr_state, 0);

    // R7 self refresh, R9 asynchronous exit
    step(0, C_REF, 2'd0, 14'h0);
    expect_eq("R7 self refresh", pwr_state, 3);
    step(0, C_ACT, 2'd1, 14'h0022);
    expect_eq("R7 held", pwr_state, 3);
    step(1, C_ACT, 2'd1, 14'h0022);
    expect_eq("R9 command after exit", bank_open, 4'b0010);

    // Random phase
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      bit k;
      bit [3:0] c;
      int pick;
      k = ($urandom % 8) != 0;
      pick = $urandom % 9;
      case (pick)
        0, 1: c = C_ACT;
        2: c = C_RD;
        3: c = C_WR;
        4: c = C_PRE;
        5: c = C_REF;
        6: c = C_MRS;
        7: c = C_NOP;
        default: c = {1'b1, 3'($urandom)};
      endcase
      step(k, c, 2'($urandom), 14'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule